// File: doc/BRIEF.md
# Fourth-Order Cascaded Biquad Filter

This block is a fixed-point fourth-order recursive filter built from two second-order sections in series. Each clock brings in one new signed fractional sample. The sample is scaled by a constant gain and then passes through the first section. The output of the first section drives the second section, and the output of the second section drives the block output. Every coefficient is fixed when the design is built. Nothing can be loaded while the block runs.

Each section keeps one two-tap history of its intermediate value. The recursive (feedback) part and the forward part both read that history. Every adder and subtractor ends in a register. As a result, the recursion sees its feedback one cycle later than an unpipelined filter would. Any reference model has to use the same timing.

No step saturates or rounds. Every narrowing is a two's-complement truncation: the value wraps, and a right shift rounds toward minus infinity. The only reset is `rst_n`, which is active-low and asynchronous. It must be released in step with `clk`.

Top module: `iir4_cascade`

## Requirements
- R1: While `rst_n` is low, `y_out` is zero, including when reset is asserted in the middle of a stream. After release with `x_in` held at zero, `y_out` stays zero.
- R2: `x_in` is a 10-bit two's-complement value with 8 fraction bits. The gain stage multiplies it by the gain coefficient G, which is a 16-bit coefficient with 12 fraction bits. The gain stage has no register.
- R3: An input sample first shows at `y_out` after four rising clock edges. A unit impulse of 256 (value 1.0) with G=1.5, B10=0.5 and B20=0.25 gives 1572864 (value 0.1875) as the first non-zero output.
- R4: A section's intermediate register is loaded with its input minus a registered feedback sum. That feedback sum is A1 times the first history tap plus A2 times the second history tap.
- R5: A section's output register is loaded with the three-input sum B0·w + B1·(first tap) + B2·(second tap). Products keep full width, and the sum is shifted right by 12 bits to drop the coefficient fraction.
- R6: The registered output of the first section is the input of the second section.
- R7: `y_out` is a 27-bit value with 23 fraction bits. It is the second section's result, shifted left by 7, keeping the low 27 bits.
- R8: Internal values are 28 bits wide with 16 fraction bits. Narrowing wraps, and right shifts round toward minus infinity, so negative inputs truncate downward.
- R9: The block accepts a new sample on every clock, and `y_out` follows the stream cycle for cycle, even when the input changes on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_in | input | 10 | Signed input sample, 8 fraction bits |
| y_out | output | 27 | Signed filtered output, 23 fraction bits |

## Verification
In each section's subtractor, a new input sample and the delayed feedback sum from older samples arrive in the same cycle. An error in either one therefore shows only when both are non-zero together. The bench provokes this overlap in three ways:
- it leaves an impulse response ringing while the input stays idle;
- it applies positive and negative steps;
- it alternates full-scale inputs on every cycle, so every cycle mixes fresh input with live feedback.

Each cycle's `y_out` is compared with a behavioural model that updates every register from the previous cycle's values.

// File: rtl/iir4_pkg.sv
package iir4_pkg;
  // Default fixed-point formats shared by the filter modules
  localparam int IN_W   = 10;  // input sample width
  localparam int IN_F   = 8;   // input fraction bits
  localparam int COEF_W = 16;  // coefficient width
  localparam int COEF_F = 12;  // coefficient fraction bits
  localparam int INT_W  = 28;  // internal datapath width
  localparam int INT_F  = 16;  // internal fraction bits
  localparam int OUT_W  = 27;  // output width
  localparam int OUT_F  = 23;  // output fraction bits
  localparam int NSEC   = 2;   // sections in the cascade
endpackage

// File: rtl/iir4_gain.sv
module iir4_gain #(
  parameter int XW   = iir4_pkg::IN_W,
  parameter int XF   = iir4_pkg::IN_F,
  parameter int CW   = iir4_pkg::COEF_W,
  parameter int CF   = iir4_pkg::COEF_F,
  parameter int IW   = iir4_pkg::INT_W,
  parameter int FRAC = iir4_pkg::INT_F,
  parameter int GAIN = 6144
) (
  input  logic signed [XW-1:0] x_in,
  output logic signed [IW-1:0] g_out
);
  localparam int GW  = XW + CW;
  localparam int EW  = GW + IW;
  localparam int GSH = XF + CF - FRAC;
  localparam logic signed [CW-1:0] GC = CW'(GAIN);

  logic signed [GW-1:0] prod;

  always_comb begin
    prod = GW'(x_in) * GW'(GC);
  end

  // Align the product's binary point to the internal format
  generate
    if (GSH >= 0) begin : g_shr
      always_comb g_out = IW'(EW'(prod) >>> GSH);
    end else begin : g_shl
      always_comb g_out = IW'(EW'(prod) <<< (-GSH));
    end
  endgenerate
endmodule

// File: rtl/iir4_biquad.sv
module iir4_biquad #(
  parameter int IW = iir4_pkg::INT_W,
  parameter int CW = iir4_pkg::COEF_W,
  parameter int CF = iir4_pkg::COEF_F,
  parameter int A1 = 0,
  parameter int A2 = 0,
  parameter int B0 = 4096,
  parameter int B1 = 0,
  parameter int B2 = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [IW-1:0] in_val,
  output logic signed [IW-1:0] out_val
);
  localparam int SW = IW + CW + 2;
  localparam logic signed [CW-1:0] A1C = CW'(A1);
  localparam logic signed [CW-1:0] A2C = CW'(A2);
  localparam logic signed [CW-1:0] B0C = CW'(B0);
  localparam logic signed [CW-1:0] B1C = CW'(B1);
  localparam logic signed [CW-1:0] B2C = CW'(B2);

  logic signed [IW-1:0] fb_q, w_q, tap1_q, tap2_q, y_q;
  logic signed [IW-1:0] fb_d, w_d, y_d;
  logic signed [SW-1:0] p_a1, p_a2, p_b0, p_b1, p_b2;

  // Next-state: feedback sum, subtractor, feedforward three-input sum
  always_comb begin
    p_a1 = SW'(A1C) * SW'(tap1_q);
    p_a2 = SW'(A2C) * SW'(tap2_q);
    p_b0 = SW'(B0C) * SW'(w_q);
    p_b1 = SW'(B1C) * SW'(tap1_q);
    p_b2 = SW'(B2C) * SW'(tap2_q);
    fb_d = IW'((p_a1 + p_a2) >>> CF);
    w_d  = in_val - fb_q;
    y_d  = IW'((p_b0 + p_b1 + p_b2) >>> CF);
  end

  // Registers: adder pipeline stages and the two-tap history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q   <= '0;
      w_q    <= '0;
      tap1_q <= '0;
      tap2_q <= '0;
      y_q    <= '0;
    end else begin
      fb_q   <= fb_d;
      w_q    <= w_d;
      tap1_q <= w_q;
      tap2_q <= tap1_q;
      y_q    <= y_d;
    end
  end

  assign out_val = y_q;

  // R4: a silent section with zero input stays silent in the recursion
  a_r4_quiet_recursion: assert property (@(posedge clk) disable iff (!rst_n)
    (in_val == '0 && fb_q == '0 && tap1_q == '0 && tap2_q == '0) |=> (w_q == '0));

  // R5: forward sum of an all-zero history is zero
  a_r5_forward_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (w_q == '0 && tap1_q == '0 && tap2_q == '0) |=> (y_q == '0));
endmodule

// File: rtl/iir4_cascade.sv
module iir4_cascade #(
  parameter int XW   = iir4_pkg::IN_W,
  parameter int XF   = iir4_pkg::IN_F,
  parameter int CW   = iir4_pkg::COEF_W,
  parameter int CF   = iir4_pkg::COEF_F,
  parameter int IW   = iir4_pkg::INT_W,
  parameter int FRAC = iir4_pkg::INT_F,
  parameter int YW   = iir4_pkg::OUT_W,
  parameter int YF   = iir4_pkg::OUT_F,
  parameter int G    = 6144,
  parameter int A11  = -2048,
  parameter int A12  = 1024,
  parameter int B10  = 2048,
  parameter int B11  = 4096,
  parameter int B12  = 2048,
  parameter int A21  = 1536,
  parameter int A22  = -1024,
  parameter int B20  = 1024,
  parameter int B21  = -2048,
  parameter int B22  = 3072
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [XW-1:0] x_in,
  output logic signed [YW-1:0] y_out
);
  localparam int NS  = iir4_pkg::NSEC;
  localparam int OSH = YF - FRAC;
  localparam int EW  = IW + YW;
  localparam int A1_T [NS] = '{A11, A21};
  localparam int A2_T [NS] = '{A12, A22};
  localparam int B0_T [NS] = '{B10, B20};
  localparam int B1_T [NS] = '{B11, B21};
  localparam int B2_T [NS] = '{B12, B22};

  logic signed [IW-1:0] chain [NS+1];

  iir4_gain #(
    .XW(XW), .XF(XF), .CW(CW), .CF(CF), .IW(IW), .FRAC(FRAC), .GAIN(G)
  ) u_gain (
    .x_in  (x_in),
    .g_out (chain[0])
  );

  generate
    for (genvar s = 0; s < NS; s++) begin : g_sec
      iir4_biquad #(
        .IW(IW), .CW(CW), .CF(CF),
        .A1(A1_T[s]), .A2(A2_T[s]),
        .B0(B0_T[s]), .B1(B1_T[s]), .B2(B2_T[s])
      ) u_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_val  (chain[s]),
        .out_val (chain[s+1])
      );
    end
  endgenerate

  // Output format conversion: truncate or extend only
  generate
    if (OSH >= 0) begin : g_oshl
      always_comb y_out = YW'(EW'(chain[NS]) <<< OSH);
    end else begin : g_oshr
      always_comb y_out = YW'(EW'(chain[NS]) >>> (-OSH));
    end
  endgenerate

  // R1: first sampled edge after reset release shows a zero output
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (y_out == '0));

  // R2: a zero sample leaves the gain stage as zero
  a_r2_gain_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (x_in == '0) |-> (chain[0] == '0));
endmodule

// File: tb/iir4_cascade_tb.sv
`timescale 1ns/1ps
module iir4_cascade_tb;
  localparam int G = 6144;
  localparam int A1 [2] = '{-2048, 1536};
  localparam int A2 [2] = '{1024, -1024};
  localparam int B0 [2] = '{2048, 1024};
  localparam int B1 [2] = '{4096, -2048};
  localparam int B2 [2] = '{2048, 3072};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [9:0]  x_in = '0;
  logic signed [26:0] y_out;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  longint m_fb [2], m_w [2], m_t1 [2], m_t2 [2], m_y [2];

  always #2 clk = ~clk;

  iir4_cascade #(
    .G(G), .A11(A1[0]), .A12(A2[0]), .B10(B0[0]), .B11(B1[0]), .B12(B2[0]),
    .A21(A1[1]), .A22(A2[1]), .B20(B0[1]), .B21(B1[1]), .B22(B2[1])
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .x_in(x_in), .y_out(y_out)
  );

  function automatic longint wr(input longint v, input int n);
    longint t;
    t = v <<< (64 - n);
    return t >>> (64 - n);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 2; s++) begin
      m_fb[s] = 0; m_w[s] = 0; m_t1[s] = 0; m_t2[s] = 0; m_y[s] = 0;
    end
  endtask

  function automatic longint model_out();
    return wr(m_y[1] <<< 7, 27);
  endfunction

  // Behavioural update of every register from its previous value
  task automatic model_tick(input longint xv);
    longint inp [2];
    longint nfb [2], nw [2], ny [2];
    inp[0] = wr((xv * G) >>> 4, 28);
    inp[1] = m_y[0];
    for (int s = 0; s < 2; s++) begin
      nfb[s] = wr((A1[s] * m_t1[s] + A2[s] * m_t2[s]) >>> 12, 28);
      nw[s]  = wr(inp[s] - m_fb[s], 28);
      ny[s]  = wr((B0[s] * m_w[s] + B1[s] * m_t1[s] + B2[s] * m_t2[s]) >>> 12, 28);
    end
    for (int s = 0; s < 2; s++) begin
      m_t2[s] = m_t1[s];
      m_t1[s] = m_w[s];
      m_fb[s] = nfb[s];
      m_w[s]  = nw[s];
      m_y[s]  = ny[s];
    end
  endtask

  task automatic cycle(input int xv, input string req);
    x_in = 10'(xv);
    @(posedge clk);
    model_tick(longint'(xv));
    @(negedge clk);
    check(req, longint'(y_out), model_out());
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 in reset", longint'(y_out), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) cycle(0, "R1 idle after reset");

    // Impulse: exact latency and value (R2, R3, R7)
    cycle(256, "R3 impulse cycle 0");
    check("R3 no output after one edge", longint'(y_out), 0);
    cycle(0, "R3 impulse cycle 1");
    check("R3 no output after two edges", longint'(y_out), 0);
    cycle(0, "R3 impulse cycle 2");
    check("R3 no output after three edges", longint'(y_out), 0);
    cycle(0, "R3 impulse cycle 3");
    check("R3 R7 first output after four edges", longint'(y_out), 1572864);
    for (int i = 0; i < 40; i++) cycle(0, "R4 R5 impulse ringing");

    // Steps and full-scale alternation with live feedback
    for (int i = 0; i < 60; i++) cycle(256, "R6 positive step");
    for (int i = 0; i < 60; i++) cycle(-300, "R8 negative step floor");
    for (int i = 0; i < 40; i++) cycle((i % 2 == 0) ? 511 : -512, "R9 R2 per-cycle alternation");
    for (int i = 0; i < 30; i++) cycle((i * 37) % 200 - 100, "R9 ramp pattern");

    // Reset asserted in the middle of a stream
    x_in = 10'sd200;
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 asynchronous reset mid-stream", longint'(y_out), 0);
    model_clear();
    @(negedge clk);
    check("R1 held in reset", longint'(y_out), 0);
    x_in = '0;
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) cycle(0, "R1 idle after second reset");
    for (int i = 0; i < 20; i++) cycle(-512, "R8 full negative step");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule